// File: doc/BRIEF.md
# Accumulator Machine Processor Core

This block is a small sequential processor built around a single 16-bit accumulator and a 12-bit program counter. Each 16-bit instruction word carries a 4-bit operation code in its upper bits and a 12-bit direct address in its lower bits. The core fetches instructions and data through one synchronous memory port, whose read data appears one clock after the address is presented. It can load, store, add, subtract, jump unconditionally, jump when the accumulator is non-negative, jump when the accumulator is non-zero, and stop. The accumulator is brought out on a port so that a program's progress can be observed.

Control is a four-state machine. FETCH drives the program counter onto the address bus and always moves to EXEC. EXEC decodes the word returned by memory. A load, add or subtract drives the operand address and moves to READ. A stop moves to HALT. Every other operation completes in EXEC and returns to FETCH: a store writes the accumulator, a jump updates the program counter, and a no-operation or untaken jump advances it. READ combines the returned data word into the accumulator, advances the program counter and returns to FETCH. HALT has no exit except reset. Instructions sit at addresses two apart, so a non-branching instruction adds 2 to the program counter.

A user places a program at address 0, holds the active-low reset for at least one clock, releases it, and waits for the halted output.

Top module: `acc_core`

## Requirements
- R1: While reset is low and after it is released, the program counter and accumulator are zero, halted is 0, mem_we is 0 and mem_addr shows 0x000, which is the first fetch address.
- R2: Opcode 0x0 (load) replaces the accumulator with the memory word at the 12-bit address field S.
- R3: Opcode 0x1 (store) writes the accumulator to address S in a single write cycle, and it leaves the accumulator unchanged.
- R4: Opcode 0x2 (add) adds the word at S to the accumulator modulo 2^16, so 0x7FFF+1 gives 0x8000 and 0xFFFF+1 gives 0x0000.
- R5: Opcode 0x3 (subtract) subtracts the word at S from the accumulator modulo 2^16, so 0x8000-0x8001 gives 0xFFFF.
- R6: Opcode 0x4 sets the program counter to S unconditionally, and instructions between the jump and its target are not executed.
- R7: Opcode 0x5 jumps to S when accumulator bit 15 is 0, which includes an accumulator of zero. Otherwise it advances the program counter by 2.
- R8: Opcode 0x6 jumps to S when the accumulator is not zero. Otherwise it advances the program counter by 2.
- R9: Opcode 0x7 halts the core. From then on halted stays 1, the accumulator and mem_addr hold their values, and mem_we stays 0 until reset. After reset the core restarts at address 0.
- R10: Opcodes 0x8 to 0xF change neither the accumulator nor memory, and they advance the program counter by 2.
- R11: Load, add and subtract take 3 clocks each (FETCH, EXEC, READ). Every other opcode takes 2 clocks (FETCH, EXEC). Halted rises at the clock edge that ends the EXEC state of the stop instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset and restart |
| mem_addr | output | 12 | Memory address, instruction or operand |
| mem_wdata | output | 16 | Data to write, equal to the accumulator |
| mem_rdata | input | 16 | Memory read data, valid one clock after its address |
| mem_we | output | 1 | Write strobe for one cycle of a store |
| halted | output | 1 | High once a stop instruction has executed |
| acc_out | output | 16 | Current accumulator value |

## Verification
A wrong state or a wrong transition in this controller changes the number of clocks between the release of reset and the rise of halted. Each program is therefore checked for its exact cycle count, and that count exposes a mistake in the very program that contains the faulty instruction. A wrong program-counter update or a wrong branch decision executes the wrong path, which shows up as a different final accumulator value or a memory word that is wrong or wrongly overwritten. After a halt, the outputs are watched for many clocks, so that a machine that leaks out of HALT is caught within one cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_READ  = 2'd2,
        ST_HALT  = 2'd3
    } state_t;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 4'b0000,
        OP_STORE   = 4'b0001,
        OP_ADD     = 4'b0010,
        OP_SUB     = 4'b0011,
        OP_JUMP    = 4'b0100,
        OP_JNONNEG = 4'b0101,
        OP_JNZ     = 4'b0110,
        OP_STOP    = 4'b0111
    } opcode_t;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_t;

    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_ALWAYS  = 2'd1,
        BR_NONNEG  = 2'd2,
        BR_NONZERO = 2'd3
    } br_cond_t;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_JUMP = 2'd2
    } pc_op_t;

    typedef enum logic {
        SEL_PC   = 1'b0,
        SEL_OPER = 1'b1
    } addr_sel_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output alu_op_t         alu_op,
    output br_cond_t        br_cond,
    output logic            is_read,
    output logic            is_store,
    output logic            is_stop
);

    always_comb begin
        alu_op   = ALU_PASS;
        br_cond  = BR_NONE;
        is_read  = 1'b0;
        is_store = 1'b0;
        is_stop  = 1'b0;
        case (opcode)
            OP_LOAD: begin
                is_read = 1'b1;
                alu_op  = ALU_PASS;
            end
            OP_STORE: is_store = 1'b1;
            OP_ADD: begin
                is_read = 1'b1;
                alu_op  = ALU_ADD;
            end
            OP_SUB: begin
                is_read = 1'b1;
                alu_op  = ALU_SUB;
            end
            OP_JUMP:    br_cond = BR_ALWAYS;
            OP_JNONNEG: br_cond = BR_NONNEG;
            OP_JNZ:     br_cond = BR_NONZERO;
            OP_STOP:    is_stop = 1'b1;
            default: begin
                // upper half of the code space behaves as no-operation
                br_cond = BR_NONE;
            end
        endcase
    end

endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
    import acc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      is_read,
    input  logic      is_store,
    input  logic      is_stop,
    input  br_cond_t  br_cond,
    input  logic      br_taken,
    output addr_sel_t addr_sel,
    output pc_op_t    pc_op,
    output logic      mem_we,
    output logic      acc_we,
    output logic      ir_we,
    output logic      halted
);

    state_t state_q;
    state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        addr_sel = SEL_PC;
        pc_op    = PC_HOLD;
        mem_we   = 1'b0;
        acc_we   = 1'b0;
        ir_we    = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                ir_we = 1'b1;
                if (is_stop) begin
                    state_d = ST_HALT;
                end else if (is_read) begin
                    addr_sel = SEL_OPER;
                    state_d  = ST_READ;
                end else if (is_store) begin
                    addr_sel = SEL_OPER;
                    mem_we   = 1'b1;
                    pc_op    = PC_STEP;
                    state_d  = ST_FETCH;
                end else if (br_cond != BR_NONE) begin
                    pc_op   = br_taken ? PC_JUMP : PC_STEP;
                    state_d = ST_FETCH;
                end else begin
                    pc_op   = PC_STEP;
                    state_d = ST_FETCH;
                end
            end
            ST_READ: begin
                acc_we  = 1'b1;
                pc_op   = PC_STEP;
                state_d = ST_FETCH;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
        endcase
    end

    assign halted = (state_q == ST_HALT);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we); // R9

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R3

    AST_READ_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> ($past(state_q) == ST_EXEC)); // R11

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  alu_op_t           dec_alu_op,
    input  br_cond_t          br_cond,
    input  addr_sel_t         addr_sel,
    input  pc_op_t            pc_op,
    input  logic              acc_we,
    input  logic              ir_we,
    output logic              br_taken,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] acc
);

    localparam logic [ADDR_W-1:0] PC_INCR = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] acc_q;
    alu_op_t           alu_op_q;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] alu_res;

    assign operand = mem_rdata[ADDR_W-1:0];

    // branch condition on the current accumulator
    always_comb begin
        case (br_cond)
            BR_ALWAYS:  br_taken = 1'b1;
            BR_NONNEG:  br_taken = ~acc_q[DATA_W-1];
            BR_NONZERO: br_taken = |acc_q;
            default:    br_taken = 1'b0;
        endcase
    end

    // arithmetic on the data word returned in READ
    always_comb begin
        case (alu_op_q)
            ALU_ADD: alu_res = acc_q + mem_rdata;
            ALU_SUB: alu_res = acc_q - mem_rdata;
            default: alu_res = mem_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alu_op_q <= ALU_PASS;
        end else if (ir_we) begin
            alu_op_q <= dec_alu_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= alu_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (pc_op)
                PC_STEP: pc_q <= pc_q + PC_INCR;
                PC_JUMP: pc_q <= operand;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign mem_addr  = (addr_sel == SEL_OPER) ? operand : pc_q;
    assign mem_wdata = acc_q;
    assign acc       = acc_q;

    AST_ACC_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> $past(acc_we)); // R2

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out
);

    localparam int OPC_LSB = DATA_W - OP_W;

    logic [OP_W-1:0] opcode;
    alu_op_t         dec_alu_op;
    br_cond_t        dec_br_cond;
    logic            dec_is_read;
    logic            dec_is_store;
    logic            dec_is_stop;
    logic            br_taken;
    addr_sel_t       addr_sel;
    pc_op_t          pc_op;
    logic            acc_we;
    logic            ir_we;

    assign opcode = mem_rdata[DATA_W-1:OPC_LSB];

    acc_decode u_decode (
        .opcode   (opcode),
        .alu_op   (dec_alu_op),
        .br_cond  (dec_br_cond),
        .is_read  (dec_is_read),
        .is_store (dec_is_store),
        .is_stop  (dec_is_stop)
    );

    acc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_read  (dec_is_read),
        .is_store (dec_is_store),
        .is_stop  (dec_is_stop),
        .br_cond  (dec_br_cond),
        .br_taken (br_taken),
        .addr_sel (addr_sel),
        .pc_op    (pc_op),
        .mem_we   (mem_we),
        .acc_we   (acc_we),
        .ir_we    (ir_we),
        .halted   (halted)
    );

    acc_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rdata  (mem_rdata),
        .dec_alu_op (dec_alu_op),
        .br_cond    (dec_br_cond),
        .addr_sel   (addr_sel),
        .pc_op      (pc_op),
        .acc_we     (acc_we),
        .ir_we      (ir_we),
        .br_taken   (br_taken),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .acc        (acc_out)
    );

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(acc_out) && $stable(mem_addr))); // R9

endmodule

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic        halted;
    logic [15:0] acc_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [0:2047];

    always #2.5 clk = ~clk;

    acc_core u_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .acc_out   (acc_out)
    );

    // synchronous memory, one clock of read latency, word at byte address
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:1]];
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] w);
        mem[a[11:1]] = w;
    endtask

    function automatic logic [15:0] peek(input logic [11:0] a);
        return mem[a[11:1]];
    endfunction

    // reset, release, count clocks until halted
    task automatic run(output int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        while (cycles < 2000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 halted in reset", {15'd0, halted}, 16'h0000);
        check("R1 mem_we in reset", {15'd0, mem_we}, 16'h0000);
        check("R1 first fetch address", {4'd0, mem_addr}, 16'h0000);
        check("R1 accumulator in reset", acc_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 halted after release", {15'd0, halted}, 16'h0000);
    endtask

    task automatic t_load_store();
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        put(12'h002, enc(4'h1, 12'h102));
        put(12'h004, enc(4'h7, 12'h000));
        put(12'h100, 16'h1234);
        run(cyc);
        check("R2 load value", acc_out, 16'h1234);
        check("R3 stored word", peek(12'h102), 16'h1234);
        check("R11 load/store/stop cycles", 16'(cyc), 16'd7);
    endtask

    task automatic t_add_sub();
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        put(12'h002, enc(4'h2, 12'h102));
        put(12'h004, enc(4'h1, 12'h104));
        put(12'h006, enc(4'h3, 12'h106));
        put(12'h008, enc(4'h1, 12'h108));
        put(12'h00A, enc(4'h2, 12'h10A));
        put(12'h00C, enc(4'h1, 12'h10C));
        put(12'h00E, enc(4'h7, 12'h000));
        put(12'h100, 16'h7FFF);
        put(12'h102, 16'h0001);
        put(12'h106, 16'h8001);
        put(12'h10A, 16'h0001);
        put(12'h10C, 16'hDEAD);
        run(cyc);
        check("R4 add into sign bit", peek(12'h104), 16'h8000);
        check("R5 subtract wraps", peek(12'h108), 16'hFFFF);
        check("R4 add wraps to zero", peek(12'h10C), 16'h0000);
        check("R4 final accumulator", acc_out, 16'h0000);
        check("R11 arithmetic program cycles", 16'(cyc), 16'd20);
    endtask

    task automatic t_countdown();
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        put(12'h002, enc(4'h3, 12'h104));
        put(12'h004, enc(4'h1, 12'h100));
        put(12'h006, enc(4'h6, 12'h000));
        put(12'h008, enc(4'h7, 12'h000));
        put(12'h100, 16'd5);
        put(12'h104, 16'd1);
        run(cyc);
        check("R8 loop ends at zero", acc_out, 16'h0000);
        check("R8 counter in memory", peek(12'h100), 16'h0000);
        check("R8 taken/untaken cycle count", 16'(cyc), 16'd52);
    endtask

    task automatic t_jump();
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h4, 12'h008));
        put(12'h002, enc(4'h0, 12'h102));
        put(12'h004, enc(4'h1, 12'h104));
        put(12'h006, enc(4'h7, 12'h000));
        put(12'h008, enc(4'h0, 12'h100));
        put(12'h00A, enc(4'h7, 12'h000));
        put(12'h100, 16'h0042);
        put(12'h102, 16'h0BAD);
        run(cyc);
        check("R6 jump target executed", acc_out, 16'h0042);
        check("R6 skipped store", peek(12'h104), 16'h0000);
        check("R6 jump cycles", 16'(cyc), 16'd7);
    endtask

    task automatic t_jnonneg(input logic [15:0] start, input logic [15:0] exp, input string tag);
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        put(12'h002, enc(4'h5, 12'h00A));
        put(12'h004, enc(4'h0, 12'h102));
        put(12'h006, enc(4'h7, 12'h000));
        put(12'h00A, enc(4'h0, 12'h104));
        put(12'h00C, enc(4'h7, 12'h000));
        put(12'h100, start);
        put(12'h102, 16'h1111);
        put(12'h104, 16'h2222);
        run(cyc);
        check(tag, acc_out, exp);
        check("R7 branch program cycles", 16'(cyc), 16'd10);
    endtask

    task automatic t_nop();
        int cyc;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        for (int k = 0; k < 8; k++) put(12'(2 + 2 * k), enc(4'(8 + k), 12'h102));
        put(12'h012, enc(4'h1, 12'h104));
        put(12'h014, enc(4'h7, 12'h000));
        put(12'h100, 16'h5A5A);
        put(12'h102, 16'h0F0F);
        run(cyc);
        check("R10 accumulator kept", acc_out, 16'h5A5A);
        check("R10 operand word untouched", peek(12'h102), 16'h0F0F);
        check("R10 store after no-ops", peek(12'h104), 16'h5A5A);
        check("R10 no-op cycles", 16'(cyc), 16'd23);
    endtask

    task automatic t_halt();
        int cyc;
        int bad_h = 0;
        int bad_a = 0;
        int bad_w = 0;
        clear_mem();
        put(12'h000, enc(4'h0, 12'h100));
        put(12'h002, enc(4'h7, 12'h000));
        put(12'h004, enc(4'h1, 12'h106));
        put(12'h100, 16'h3333);
        run(cyc);
        check("R11 halt timing", 16'(cyc), 16'd5);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (halted !== 1'b1) bad_h++;
            if (acc_out !== 16'h3333) bad_a++;
            if (mem_we !== 1'b0) bad_w++;
        end
        check("R9 halted held", 16'(bad_h), 16'd0);
        check("R9 accumulator held", 16'(bad_a), 16'd0);
        check("R9 no writes while halted", 16'(bad_w), 16'd0);
        check("R9 nothing executed past stop", peek(12'h106), 16'h0000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears halted", {15'd0, halted}, 16'h0000);
        check("R9 restart address", {4'd0, mem_addr}, 16'h0000);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog R11 actual=hung expected=halt");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_load_store();
        t_add_sub();
        t_countdown();
        t_jump();
        t_jnonneg(16'h0000, 16'h2222, "R7 taken on zero");
        t_jnonneg(16'h7FFF, 16'h2222, "R7 taken on positive");
        t_jnonneg(16'h8000, 16'h1111, "R7 untaken on negative");
        t_nop();
        t_halt();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule